// File: doc/BRIEF.md
# Interrupt capture and hold unit

This unit takes an interrupt level from a small set of request lines and keeps it on view for a fixed time. Each request line stands for one interrupt level. When exactly one line is high and the unit is idle, an enabled encoder turns that line's number into a binary code. A register built from toggle flip-flops loads the code on the next clock edge.

While the stored code is nonzero, the unit is busy. During that time the encoder is switched off and the register accepts nothing new. This gives software a stable window in which to service the level. A hold timer runs during the window. It is an up/down counter, and its direction is chosen at the moment of capture. When the timer reaches its final state, the register toggles back to zero. The encoder is then enabled again, and the next request can be captured.

Top module: `irq_hold_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the register and the timer are cleared. After that edge `held_code` is 0 and `busy` is 0, whatever the request lines carry.
- R2: When the unit is idle and exactly one request line is high, `held_code` shows that line's number one edge later. Bit 0 of `irq_req` is line 1, bit 1 is line 2 and bit 2 is line 3, so the code is 1, 2 or 3.
- R3: When the unit is idle and the request lines are all zero, or more than one line is high, nothing is captured. `busy` stays 0 and `held_code` stays 0.
- R4: While busy, a change on the request lines has no effect. `held_code` keeps the captured value until the hold ends.
- R5: With `count_down` = 0 (count up from 0 to 4), the captured code stays visible for exactly 5 clock cycles after the load edge. It then returns to 0.
- R6: With `count_down` = 1 (count down from 4 to 0), the captured code also stays visible for exactly 5 clock cycles.
- R7: `count_down` is sampled only at the load edge. Changing it during a hold does not change the hold length.
- R8: In the cycle after the register clears, the encoder is enabled again. A single request present in that cycle is captured on the next edge.
- R9: `busy` is 1 exactly when `held_code` is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 3 | Request lines; bit i is line i+1, expected one-hot |
| count_down | input | 1 | Timer direction taken at capture: 0 counts up, 1 counts down |
| held_code | output | 2 | Captured line number; 0 when idle |
| busy | output | 1 | High while a code is held |

## Verification
The bench builds the unit with its default parameters: three request lines and a five-cycle hold. These values make every code from 1 to 3 reachable, along with the invalid multi-hot patterns. With them, the exact hold length can be counted cycle by cycle in both timer directions. The scenarios also cover:
- a request that arrives during a hold;
- a direction flip during a hold;
- a request waiting at the moment the register clears, which checks that re-capture comes one cycle after the clear.

// File: rtl/irq_hold_pkg.sv
// Shared types and defaults for the interrupt capture and hold unit.
package irq_hold_pkg;
    // Default number of request lines.
    localparam int DEF_NUM_REQ = 3;
    // Default hold length in clock cycles.
    localparam int DEF_HOLD_CYCLES = 5;

    // Hold timer direction, latched at capture time.
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } hold_dir_e;
endpackage

// File: rtl/irq_line_encoder.sv
// Encoder with enable.
// Output: the number (index + 1) of the single high request line.
// Assumes one-hot input.
// Gives 0 in any of these cases:
//   - enable is low;
//   - no line is high;
//   - more than one line is high.
// No priority is applied between lines.
module irq_line_encoder #(
    parameter int NUM_REQ = 3,
    parameter int CODE_W  = $clog2(NUM_REQ + 1)
) (
    input  logic [NUM_REQ-1:0] req,
    input  logic               en,
    output logic [CODE_W-1:0]  code
);
    localparam int HIT_W = $clog2(NUM_REQ + 1) + 1;

    logic [HIT_W-1:0]  hits;
    logic [CODE_W-1:0] raw;

    // Count the high lines and remember the number of the last one seen.
    always_comb begin
        hits = '0;
        raw  = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (req[i]) begin
                hits = hits + HIT_W'(1);
                raw  = CODE_W'(i + 1);
            end
        end
    end

    // Pass the code only when enabled and exactly one line is high.
    always_comb begin
        code = (en && (hits == HIT_W'(1))) ? raw : '0;
    end
endmodule

// File: rtl/irq_toggle_reg.sv
// Parallel-load register made of toggle flip-flops.
// Each bit flips when its T input is 1:
//   - on load, T = D xor Q;
//   - on clear, T = Q.
// Assumes load and clear are never asserted together.
// Reset is synchronous and active-low.
module irq_toggle_reg #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clear,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             nonzero
);
    logic [WIDTH-1:0] t;

    // Work out which bits must flip for a load or for a clear.
    always_comb begin
        if (load)       t = d ^ q;
        else if (clear) t = q;
        else            t = '0;
    end

    // One toggle flip-flop per bit.
    for (genvar b = 0; b < WIDTH; b++) begin : g_tff
        // Flip the bit when its T input is 1; reset forces it to 0.
        always_ff @(posedge clk) begin
            if (!rst_n)    q[b] <= 1'b0;
            else if (t[b]) q[b] <= ~q[b];
        end
    end

    // Flag a stored value other than zero.
    always_comb begin
        nonzero = |q;
    end
endmodule

// File: rtl/irq_hold_timer.sv
// Up/down hold timer.
// On start it latches the direction and loads the first state:
//   - counting up starts from 0;
//   - counting down starts from HOLD_CYCLES - 1.
// While active it steps once per clock.
// done is high in the final state: HOLD_CYCLES - 1 going up, 0 going down.
// Assumes start only comes while idle.
module irq_hold_timer
    import irq_hold_pkg::*;
#(
    parameter int HOLD_CYCLES = 5,
    parameter int CNT_W       = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic dir_in,
    input  logic active,
    output logic done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

    logic [CNT_W-1:0] cnt;
    hold_dir_e        dir_q;

    // Final-state detect for the latched direction.
    always_comb begin
        done = (dir_q == DIR_DOWN) ? (cnt == '0) : (cnt == LAST);
    end

    // Load on start, then step toward the final state while active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            dir_q <= DIR_UP;
        end else if (start) begin
            dir_q <= hold_dir_e'(dir_in);
            cnt   <= dir_in ? LAST : '0;
        end else if (active && !done) begin
            if (dir_q == DIR_DOWN) cnt <= cnt - CNT_W'(1);
            else                   cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/irq_hold_top.sv
// Interrupt capture and hold unit.
// The encoder is enabled only while the register is zero.
// A valid request is loaded into the toggle register and starts the hold timer.
// When the timer reaches its final state, the register is cleared.
// Assumes one-hot requests; other patterns are dropped.
module irq_hold_top
    import irq_hold_pkg::*;
#(
    parameter int NUM_REQ     = DEF_NUM_REQ,
    parameter int HOLD_CYCLES = DEF_HOLD_CYCLES
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_REQ-1:0]              irq_req,
    input  logic                            count_down,
    output logic [$clog2(NUM_REQ + 1)-1:0]  held_code,
    output logic                            busy
);
    localparam int CODE_W = $clog2(NUM_REQ + 1);

    logic              enc_en;
    logic [CODE_W-1:0] enc_code;
    logic              do_load;
    logic              do_clear;
    logic              hold_done;
    logic              reg_nz;

    // Gate the encoder off while a code is held, and derive load and clear.
    always_comb begin
        enc_en   = ~reg_nz;
        do_load  = (enc_code != '0);
        do_clear = reg_nz & hold_done;
        busy     = reg_nz;
    end

    irq_line_encoder #(.NUM_REQ(NUM_REQ), .CODE_W(CODE_W)) u_enc (
        .req  (irq_req),
        .en   (enc_en),
        .code (enc_code)
    );

    irq_toggle_reg #(.WIDTH(CODE_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (do_load),
        .clear   (do_clear),
        .d       (enc_code),
        .q       (held_code),
        .nonzero (reg_nz)
    );

    irq_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (do_load),
        .dir_in (count_down),
        .active (reg_nz),
        .done   (hold_done)
    );
endmodule

// File: rtl/irq_hold_checker.sv
// Assertion checker for irq_hold_top, attached with bind.
// Counts the length of each busy run and checks it against HOLD_CYCLES.
module irq_hold_checker #(
    parameter int NUM_REQ     = 3,
    parameter int CODE_W      = 2,
    parameter int HOLD_CYCLES = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REQ-1:0] irq_req,
    input logic [CODE_W-1:0]  held_code,
    input logic               busy
);
    localparam int RUN_W = $clog2(HOLD_CYCLES + 2) + 1;

    logic [RUN_W-1:0] run_len;

    // Count the cycles of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + RUN_W'(1);
        else           run_len <= '0;
    end

    // R9: busy agrees with the held code
    a_r9_busy_code: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (held_code != '0));

    // R2: a single request while idle starts a hold
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $countones(irq_req) == 1) |=> busy);

    // R3: zero or multi-hot requests while idle leave the unit idle
    a_r3_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $countones(irq_req) != 1) |=> !busy);

    // R4: the held code does not change while busy, apart from the clear
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (held_code == $past(held_code)) || (held_code == '0));

    // R5: a busy run never grows past the hold length
    a_r5_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < RUN_W'(HOLD_CYCLES)));

    // R6: each busy run ends at exactly the hold length
    a_r6_exact_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == RUN_W'(HOLD_CYCLES)));
endmodule

bind irq_hold_top irq_hold_checker #(
    .NUM_REQ     (NUM_REQ),
    .CODE_W      (CODE_W),
    .HOLD_CYCLES (HOLD_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .held_code (held_code),
    .busy      (busy)
);

// File: tb/sim_irq_hold_top.sv
// Directed bench for irq_hold_top.
// Inputs are driven and outputs sampled 1 ns after each rising edge.
module sim_irq_hold_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] irq_req = 3'b000;
    logic       count_down = 1'b0;
    logic [1:0] held_code;
    logic       busy;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    irq_hold_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_req    (irq_req),
        .count_down (count_down),
        .held_code  (held_code),
        .busy       (busy)
    );

    // 250 MHz clock.
    always #2 clk = ~clk;

    // Compare one observed value with its expected value.
    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Advance one clock and settle past the edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Check the outputs, including the busy/code agreement.
    task automatic chk_out(input string tag, input int code, input int bsy);
        chk({tag, " code"}, int'(held_code), code);
        chk({tag, " busy"}, int'(busy), bsy);
        chk("R9 busy matches code", int'(busy), int'(held_code != 2'd0));
    endtask

    // R1: hold reset low with requests present.
    task automatic t_reset();
        rst_n = 1'b0;
        irq_req = 3'b001;
        step();
        step();
        chk_out("R1 reset", 0, 0);
        irq_req = 3'b000;
        rst_n = 1'b1;
        step();
        chk_out("R1 idle after reset", 0, 0);
    endtask

    // Capture req, then count the busy cycles.
    // During the hold, hold_req is applied and the direction may be flipped.
    task automatic t_hold(input string tag, input logic [2:0] req,
                          input logic dir, input int exp_code,
                          input logic [2:0] hold_req, input bit flip);
        int len = 0;
        irq_req = req;
        count_down = dir;
        step();
        chk_out({"R2 capture ", tag}, exp_code, 1);
        irq_req = hold_req;
        while (busy && len < 12) begin
            chk({"R4 held code ", tag}, int'(held_code), exp_code);
            len++;
            if (flip && len == 2) count_down = ~count_down;
            step();
        end
        if (flip)     chk({"R7 length ", tag}, len, 5);
        else if (dir) chk({"R6 length ", tag}, len, 5);
        else          chk({"R5 length ", tag}, len, 5);
        chk_out({"R5 cleared ", tag}, 0, 0);
    endtask

    // R3: invalid patterns while idle are not captured.
    task automatic t_invalid(input logic [2:0] req);
        irq_req = req;
        step();
        chk_out("R3 no capture", 0, 0);
        step();
        chk_out("R3 still idle", 0, 0);
        irq_req = 3'b000;
    endtask

    // R8: a request waiting at the clear is taken one cycle later.
    task automatic t_recapture();
        irq_req = 3'b010;
        count_down = 1'b0;
        step();
        chk_out("R8 first capture", 2, 1);
        irq_req = 3'b100;
        for (int i = 0; i < 4; i++) step();
        chk_out("R8 last held cycle", 2, 1);
        step();
        chk_out("R8 cleared", 0, 0);
        step();
        chk_out("R8 recaptured", 3, 1);
        irq_req = 3'b000;
        for (int i = 0; i < 5; i++) step();
        chk_out("R8 second clear", 0, 0);
    endtask

    initial begin
        t_reset();
        t_hold("line1 up",    3'b001, 1'b0, 1, 3'b000, 1'b0);
        t_hold("line2 down",  3'b010, 1'b1, 2, 3'b000, 1'b0);
        t_hold("line3 up",    3'b100, 1'b0, 3, 3'b000, 1'b0);
        t_hold("ignore req",  3'b001, 1'b1, 1, 3'b100, 1'b0);
        t_hold("flip up",     3'b010, 1'b0, 2, 3'b000, 1'b1);
        t_hold("flip down",   3'b100, 1'b1, 3, 3'b000, 1'b1);
        t_invalid(3'b000);
        t_invalid(3'b011);
        t_invalid(3'b111);
        t_recapture();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #400000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end
endmodule